// File: doc/BRIEF.md
# Age-Counter Replacement Selector

This block holds the replacement state for a set-associative tag store. Every way of every set has a small age counter. A larger age means the way has gone longer without use. Two kinds of update reach the block, one per cycle, each aimed at a single set:

- A hit update refreshes one way and ages the ways that were more recently used than it.
- A fill update ages the whole set and marks the newly written way as the youngest.

A separate query port names a set and carries that set's per-way valid bits from the tag store. The block answers, combinationally, with the way that should be replaced next and with the raw ages of that set.

An empty way is always preferred as the replacement candidate. When every way holds data, the oldest way is chosen. If several ways share the oldest age, the lowest-numbered one wins. With `NUM_SETS` set to 1, the same block serves a small fully associative victim buffer: it drops its set addressing and keeps a single row of ages. In that use, a swap between the main array and the buffer is presented as a hit update on the buffer entry.

Top module: `age_repl_sel`

## Requirements
- R1: While reset is asserted, and immediately after it, every age of every set reads zero on `qry_ages`.
- R2: A hit update (`hit_en`=1, `fill_en`=0) on way h of set s takes effect at the next clock edge. Every other way of s whose age is strictly below h's age gains one, and h's age becomes zero. Ways whose age is at or above h's age keep their value.
- R3: A fill update (`fill_en`=1) into way f of set s takes effect at the next clock edge. Every other way of s gains one, and f's age becomes zero.
- R4: An age never exceeds `NUM_WAYS`-1. An increment applied to an age already at that value leaves it there.
- R5: When any bit of `qry_valid` is 0, `cand_way` is the lowest-numbered way whose valid bit is 0.
- R6: When all bits of `qry_valid` are 1, `cand_way` is a way holding the largest age in the queried set.
- R7: When several ways share that largest age, `cand_way` is the lowest-numbered of them.
- R8: When `hit_en` and `fill_en` are both 1 in the same cycle, only the fill update is applied.
- R9: An update changes only the set named by `upd_set`. A cycle with neither enable set changes nothing.
- R10: `cand_way` and `qry_ages` follow `qry_set` and `qry_valid` combinationally. An update request is not visible on them before the clock edge that applies it.
- R11: With `NUM_SETS`=1, the single row of ages follows R2 to R7, and the set index inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_set | input | SET_W | Set receiving this cycle's update |
| hit_en | input | 1 | Apply a hit update |
| hit_way | input | WAY_W | Way that was hit |
| fill_en | input | 1 | Apply a fill update (wins over a hit) |
| fill_way | input | WAY_W | Way being filled |
| qry_set | input | SET_W | Set being queried |
| qry_valid | input | NUM_WAYS | Valid bit of each way in the queried set, bit w for way w |
| qry_ages | output | NUM_WAYS*AGE_W | Ages of the queried set, way w at bits [w*AGE_W +: AGE_W] |
| cand_way | output | WAY_W | Replacement candidate for the queried set |

## Verification
The bench fills the ways of one set in order. This produces distinct ages, which separates the full-set increment of a fill from the hit rule that increments only younger ways. It then hits a way in the middle of the order and then the oldest way, so only the ways below the hit age may move.

Repeated fills into a single way force the other ages to saturate and to tie. This pattern tells the tie-break apart from a plain maximum search. Valid masks with holes in several positions show that a free way overrides age. Same-cycle hit and fill requests, together with queries of untouched sets, show that the fill wins and that updates stay inside their set. A one-set instance repeats fill, swap and selection as the victim buffer would use them.

// File: rtl/age_repl_pkg.sv
package age_repl_pkg;

   // Width of an index over n items, at least one bit.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   typedef enum logic [1:0] {
      UPD_NONE = 2'd0,
      UPD_HIT  = 2'd1,
      UPD_FILL = 2'd2
   } upd_kind_e;

endpackage

// File: rtl/age_next_calc.sv
module age_next_calc
   import age_repl_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   parameter int AGE_W    = 2,
   parameter int WAY_W    = 2
) (
   input  logic [NUM_WAYS*AGE_W-1:0] ages_cur,
   input  logic                      hit_en,
   input  logic [WAY_W-1:0]          hit_way,
   input  logic                      fill_en,
   input  logic [WAY_W-1:0]          fill_way,
   output logic [NUM_WAYS*AGE_W-1:0] ages_nxt,
   output logic                      upd_go
);

   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(NUM_WAYS - 1);

   upd_kind_e        kind;
   logic [AGE_W-1:0] hit_age;

   always_comb begin
      if (fill_en)     kind = UPD_FILL;
      else if (hit_en) kind = UPD_HIT;
      else             kind = UPD_NONE;
   end

   assign upd_go  = (kind != UPD_NONE);
   assign hit_age = ages_cur[hit_way*AGE_W +: AGE_W];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic [AGE_W-1:0] cur;
      logic [AGE_W-1:0] inc;
      logic [AGE_W-1:0] nxt;

      assign cur = ages_cur[w*AGE_W +: AGE_W];
      assign inc = (cur >= AGE_MAX) ? AGE_MAX : cur + AGE_W'(1);

      always_comb begin
         unique case (kind)
            UPD_FILL: nxt = (fill_way == WAY_W'(w)) ? '0 : inc;
            UPD_HIT: begin
               if (hit_way == WAY_W'(w))  nxt = '0;
               else if (cur < hit_age)    nxt = inc;
               else                       nxt = cur;
            end
            default:  nxt = cur;
         endcase
      end

      assign ages_nxt[w*AGE_W +: AGE_W] = nxt;
   end

endmodule

// File: rtl/age_cand_pick.sv
module age_cand_pick #(
   parameter int NUM_WAYS = 4,
   parameter int AGE_W    = 2,
   parameter int WAY_W    = 2
) (
   input  logic [NUM_WAYS*AGE_W-1:0] ages,
   input  logic [NUM_WAYS-1:0]       valid,
   output logic [WAY_W-1:0]          cand_way
);

   logic [WAY_W-1:0] free_way;
   logic             free_found;
   logic [WAY_W-1:0] old_way;
   logic [AGE_W-1:0] old_age;

   // Lowest-numbered invalid way.
   always_comb begin
      free_way   = '0;
      free_found = 1'b0;
      for (int w = 0; w < NUM_WAYS; w++) begin
         if (!free_found && !valid[w]) begin
            free_way   = WAY_W'(w);
            free_found = 1'b1;
         end
      end
   end

   // Oldest way; strict compare keeps the lowest index on ties.
   always_comb begin
      old_way = '0;
      old_age = ages[0 +: AGE_W];
      for (int w = 1; w < NUM_WAYS; w++) begin
         if (ages[w*AGE_W +: AGE_W] > old_age) begin
            old_way = WAY_W'(w);
            old_age = ages[w*AGE_W +: AGE_W];
         end
      end
   end

   assign cand_way = free_found ? free_way : old_way;

endmodule

// File: rtl/age_repl_sel.sv
module age_repl_sel
   import age_repl_pkg::*;
#(
   parameter  int NUM_SETS = 8,
   parameter  int NUM_WAYS = 4,
   localparam int SET_W    = idx_width(NUM_SETS),
   localparam int WAY_W    = idx_width(NUM_WAYS),
   localparam int AGE_W    = idx_width(NUM_WAYS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [SET_W-1:0]          upd_set,
   input  logic                      hit_en,
   input  logic [WAY_W-1:0]          hit_way,
   input  logic                      fill_en,
   input  logic [WAY_W-1:0]          fill_way,
   input  logic [SET_W-1:0]          qry_set,
   input  logic [NUM_WAYS-1:0]       qry_valid,
   output logic [NUM_WAYS*AGE_W-1:0] qry_ages,
   output logic [WAY_W-1:0]          cand_way
);

   localparam int ROW_W = NUM_WAYS * AGE_W;

   if (NUM_WAYS < 2) begin : g_bad_ways
      $error("age_repl_sel: NUM_WAYS must be at least 2");
   end
   if (NUM_SETS < 1) begin : g_bad_sets
      $error("age_repl_sel: NUM_SETS must be at least 1");
   end

   logic [ROW_W-1:0] row_cur;
   logic [ROW_W-1:0] row_nxt;
   logic             upd_go;

   age_next_calc #(
      .NUM_WAYS (NUM_WAYS),
      .AGE_W    (AGE_W),
      .WAY_W    (WAY_W)
   ) u_next (
      .ages_cur (row_cur),
      .hit_en   (hit_en),
      .hit_way  (hit_way),
      .fill_en  (fill_en),
      .fill_way (fill_way),
      .ages_nxt (row_nxt),
      .upd_go   (upd_go)
   );

   if (NUM_SETS == 1) begin : g_single
      logic [ROW_W-1:0] ages_q;
      logic             set_idx_unused;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      ages_q <= '0;
         else if (upd_go) ages_q <= row_nxt;
      end

      assign row_cur        = ages_q;
      assign qry_ages       = ages_q;
      assign set_idx_unused = ^{upd_set, qry_set};
   end else begin : g_multi
      logic [ROW_W-1:0] ages_q [NUM_SETS];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) ages_q[s] <= '0;
         end else if (upd_go) begin
            ages_q[upd_set] <= row_nxt;
         end
      end

      assign row_cur  = ages_q[upd_set];
      assign qry_ages = ages_q[qry_set];
   end

   age_cand_pick #(
      .NUM_WAYS (NUM_WAYS),
      .AGE_W    (AGE_W),
      .WAY_W    (WAY_W)
   ) u_pick (
      .ages     (qry_ages),
      .valid    (qry_valid),
      .cand_way (cand_way)
   );

endmodule

// File: rtl/age_repl_chk.sv
module age_repl_chk #(
   parameter int NUM_WAYS = 4,
   parameter int AGE_W    = 2,
   parameter int WAY_W    = 2,
   parameter int SET_W    = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [SET_W-1:0]          upd_set,
   input logic                      hit_en,
   input logic [WAY_W-1:0]          hit_way,
   input logic                      fill_en,
   input logic [WAY_W-1:0]          fill_way,
   input logic [SET_W-1:0]          qry_set,
   input logic [NUM_WAYS-1:0]       qry_valid,
   input logic [NUM_WAYS*AGE_W-1:0] qry_ages,
   input logic [WAY_W-1:0]          cand_way
);

   function automatic logic [AGE_W-1:0] age_of(input logic [NUM_WAYS*AGE_W-1:0] v,
                                                input logic [WAY_W-1:0] w);
      return v[w*AGE_W +: AGE_W];
   endfunction

   function automatic logic all_in_range(input logic [NUM_WAYS*AGE_W-1:0] v);
      for (int w = 0; w < NUM_WAYS; w++)
         if (int'(v[w*AGE_W +: AGE_W]) > NUM_WAYS - 1) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic lower_all_valid(input logic [NUM_WAYS-1:0] v,
                                            input logic [WAY_W-1:0] c);
      for (int w = 0; w < NUM_WAYS; w++)
         if (w < int'(c) && !v[w]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic is_oldest(input logic [NUM_WAYS*AGE_W-1:0] v,
                                      input logic [WAY_W-1:0] c);
      for (int w = 0; w < NUM_WAYS; w++)
         if (v[w*AGE_W +: AGE_W] > age_of(v, c)) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic no_earlier_tie(input logic [NUM_WAYS*AGE_W-1:0] v,
                                           input logic [WAY_W-1:0] c);
      for (int w = 0; w < NUM_WAYS; w++)
         if (w < int'(c) && v[w*AGE_W +: AGE_W] == age_of(v, c)) return 1'b0;
      return 1'b1;
   endfunction

   // R4
   age_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_in_range(qry_ages));

   // R5
   free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_valid != '1) |-> (!qry_valid[cand_way] && lower_all_valid(qry_valid, cand_way)));

   // R6
   oldest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_valid == '1) |-> is_oldest(qry_ages, cand_way));

   // R7
   tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_valid == '1) |-> no_earlier_tie(qry_ages, cand_way));

   // R3 and R8
   fill_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (qry_set != $past(upd_set) || age_of(qry_ages, $past(fill_way)) == '0));

   // R2
   hit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_en && !fill_en) |=> (qry_set != $past(upd_set) || age_of(qry_ages, $past(hit_way)) == '0));

endmodule

bind age_repl_sel age_repl_chk #(
   .NUM_WAYS (NUM_WAYS),
   .AGE_W    (AGE_W),
   .WAY_W    (WAY_W),
   .SET_W    (SET_W)
) u_chk (.*);

// File: tb/tb_age_repl_sel.sv
module tb_age_repl_sel;

   localparam int SETS = 8;
   localparam int WAYS = 4;
   localparam int SW   = 3;
   localparam int WW   = 2;
   localparam int AW   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [SW-1:0]      upd_set = '0;
   logic               hit_en = 1'b0, fill_en = 1'b0;
   logic [WW-1:0]      hit_way = '0, fill_way = '0;
   logic [SW-1:0]      qry_set = '0;
   logic [WAYS-1:0]    qry_valid = '1;
   logic [WAYS*AW-1:0] qry_ages;
   logic [WW-1:0]      cand_way;

   age_repl_sel #(.NUM_SETS(SETS), .NUM_WAYS(WAYS)) dut (
      .clk(clk), .rst_n(rst_n), .upd_set(upd_set), .hit_en(hit_en), .hit_way(hit_way),
      .fill_en(fill_en), .fill_way(fill_way), .qry_set(qry_set), .qry_valid(qry_valid),
      .qry_ages(qry_ages), .cand_way(cand_way));

   // one-set instance used as a victim buffer
   logic               v_hit_en = 1'b0, v_fill_en = 1'b0;
   logic [WW-1:0]      v_hit_way = '0, v_fill_way = '0;
   logic [WAYS-1:0]    v_valid = '1;
   logic [WAYS*AW-1:0] v_ages;
   logic [WW-1:0]      v_cand;

   age_repl_sel #(.NUM_SETS(1), .NUM_WAYS(WAYS)) vdut (
      .clk(clk), .rst_n(rst_n), .upd_set(1'b1), .hit_en(v_hit_en), .hit_way(v_hit_way),
      .fill_en(v_fill_en), .fill_way(v_fill_way), .qry_set(1'b0), .qry_valid(v_valid),
      .qry_ages(v_ages), .cand_way(v_cand));

   int checks = 0;
   int errors = 0;
   int model [SETS][WAYS];

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_cand(input int s, input logic [WAYS-1:0] v);
      int best = 0;
      for (int w = 0; w < WAYS; w++) if (!v[w]) return w;
      for (int w = 1; w < WAYS; w++) if (model[s][w] > model[s][best]) best = w;
      return best;
   endfunction

   function automatic int sat(input int a);
      return (a >= WAYS - 1) ? WAYS - 1 : a + 1;
   endfunction

   // compare all ages and the candidate of set s under mask v
   task automatic check_set(input string req, input int s, input logic [WAYS-1:0] v);
      qry_set   = SW'(s);
      qry_valid = v;
      #1;
      for (int w = 0; w < WAYS; w++)
         check(req, int'(qry_ages[w*AW +: AW]), model[s][w]);
      check(req, int'(cand_way), exp_cand(s, v));
   endtask

   task automatic update(input int s, input bit he, input int hw, input bit fe, input int fw);
      int h_age;
      @(negedge clk);
      upd_set = SW'(s); hit_en = he; hit_way = WW'(hw); fill_en = fe; fill_way = WW'(fw);
      @(posedge clk);
      h_age = model[s][hw];
      if (fe) begin
         for (int w = 0; w < WAYS; w++) model[s][w] = (w == fw) ? 0 : sat(model[s][w]);
      end else if (he) begin
         for (int w = 0; w < WAYS; w++)
            if (w == hw) model[s][w] = 0;
            else if (model[s][w] < h_age) model[s][w] = sat(model[s][w]);
      end
      @(negedge clk);
      hit_en = 1'b0; fill_en = 1'b0;
   endtask

   task automatic t_reset;
      // R1: every set reads zero ages; R7: all tied, way 0 chosen
      for (int s = 0; s < SETS; s++) check_set("R1", s, '1);
      check("R7", int'(cand_way), 0);
   endtask

   task automatic t_fill_order;
      // R3: fills into ways 0..3 of set 2 give ages 3,2,1,0
      for (int w = 0; w < WAYS; w++) update(2, 0, 0, 1, w);
      check_set("R3", 2, '1);
      check("R3", int'(qry_ages[0 +: AW]), 3);
      check("R6", int'(cand_way), 0);
   endtask

   task automatic t_free_way;
      // R5: a hole wins over age
      check_set("R5", 2, 4'b1011);
      check("R5", int'(cand_way), 2);
      check_set("R5", 2, 4'b0101);
      check("R5", int'(cand_way), 1);
      check_set("R5", 2, 4'b0000);
      check("R5", int'(cand_way), 0);
   endtask

   task automatic t_hits;
      // R2: hit on the middle way, then on the oldest
      update(2, 1, 2, 0, 0);
      check_set("R2", 2, '1);
      check("R2", int'(qry_ages[AW +: AW]), 2);
      update(2, 1, 0, 0, 0);
      check_set("R2", 2, '1);
      check("R6", int'(cand_way), 1);
   endtask

   task automatic t_saturate;
      // R4: repeated fills into way 0 pin the others at 3; R7: tie picks way 1
      for (int i = 0; i < 5; i++) update(5, 0, 0, 1, 0);
      check_set("R4", 5, '1);
      check("R4", int'(qry_ages[3*AW +: AW]), 3);
      check("R7", int'(cand_way), 1);
   endtask

   task automatic t_both;
      // R8: hit on way 1 and fill on way 2 together; the fill wins
      update(5, 1, 1, 1, 2);
      check_set("R8", 5, '1);
      check("R8", int'(qry_ages[AW +: AW]), 3);
      check("R8", int'(qry_ages[2*AW +: AW]), 0);
   endtask

   task automatic t_isolation;
      // R9: set 2 untouched by set 5 work; idle cycle changes nothing
      check_set("R9", 2, '1);
      update(5, 0, 3, 0, 3);
      check_set("R9", 5, '1);
      check_set("R9", 0, '1);
   endtask

   task automatic t_comb;
      // R10: the query responds at once; a pending update waits for the edge
      @(negedge clk);
      qry_set = 3'd2; qry_valid = 4'b1110;
      #1 check("R10", int'(cand_way), 0);
      qry_valid = '1;
      #1 check("R10", int'(cand_way), exp_cand(2, '1));
      upd_set = 3'd2; fill_en = 1'b1; fill_way = 2'd1;
      #1 check("R10", int'(qry_ages[AW +: AW]), model[2][1]);
      @(posedge clk);
      for (int w = 0; w < WAYS; w++) model[2][w] = (w == 1) ? 0 : sat(model[2][w]);
      @(negedge clk);
      fill_en = 1'b0;
      check_set("R10", 2, '1);
   endtask

   task automatic t_victim;
      // R11: one-set instance: fill 0, fill 1, swap-hit on 0
      @(negedge clk); v_fill_en = 1'b1; v_fill_way = 2'd0;
      @(negedge clk); v_fill_way = 2'd1;
      @(negedge clk); v_fill_en = 1'b0; v_hit_en = 1'b1; v_hit_way = 2'd0;
      @(negedge clk); v_hit_en = 1'b0;
      v_valid = 4'b0011;
      #1;
      check("R11", int'(v_ages[0 +: AW]), 0);
      check("R11", int'(v_ages[AW +: AW]), 1);
      check("R11", int'(v_ages[2*AW +: AW]), 2);
      check("R11", int'(v_cand), 2);
      v_valid = '1;
      #1 check("R11", int'(v_cand), 2);
   endtask

   initial begin
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) model[s][w] = 0;
      repeat (3) @(negedge clk);
      check_set("R1", 0, '1);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill_order();
      t_free_way();
      t_hits();
      t_saturate();
      t_both();
      t_isolation();
      t_comb();
      t_victim();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule